// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port

This block is one general-purpose I/O port of eight pins. Three registers set each pin: a data latch, a direction register and an option register. Bit x of each register controls pin x. When a pin is an output, its data latch drives the pad and the output enable is high. When a pin is an input, a read of the data register returns the pin level after it passes through a synchronizer. A read of an output pin returns the latch. A write to the data register of an input pin changes only the latch. The pad sees that value when the pin is switched to output.

For an input pin, the option bit has one of two meanings, chosen per pin at build time by a capability mask. On pins that are not interrupt-capable it turns on the pull-up. On interrupt-capable pins it enables the pin as an interrupt source to an external interrupt controller, which also receives the synchronized pin levels. For an output pin the option bit has no effect on the pad controls.

Software reaches the registers over a simple single-cycle bus. Writes take effect on the clock edge. Read data is combinational and is zero when the bus is not selected.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-low reset, the data, direction and option registers all read 0. Every pin is then an input with output enable, pull-up and interrupt enable low, and the synchronized pin levels read 0.
- R2: Register addresses are 0 for data, 1 for direction, 2 for option and 3 reserved. A write happens only on a clock edge where bus_sel and bus_wr are both high.
- R3: pad_oe[x] is 1 exactly when direction bit x is 1, which makes pin x an output.
- R4: For an input pin, a read of data bit x returns pad_in[x] as sampled two clock edges earlier.
- R5: A write of data bit x updates the latch while the pin is an input, and leaves pad_oe unchanged. pad_out[x] always shows the latch, so the value written while the pin was an input drives the pad once the pin becomes an output.
- R6: For an output pin, a read of data bit x returns the latch, whatever the level on pad_in[x].
- R7: pull_up[x] is 1 only when pin x is an input, its option bit is 1, and the pin is not interrupt-capable (IRQ_MASK bit x is 0; the default mask is 8'h0F).
- R8: irq_en[x] is 1 only when pin x is an input, its option bit is 1, and the pin is interrupt-capable (IRQ_MASK bit x is 1).
- R9: The direction and option registers read back the value last written to them. The reserved address reads 0, and a write to it changes no register.
- R10: When bus_sel is low, bus_rdata is 0 and a write strobe has no effect.
- R11: pin_sync presents pad_in delayed by two clock edges for the external interrupt controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pad_in | input | 8 | Raw pin levels from the pads |
| pad_out | output | 8 | Data latch value to the pad drivers |
| pad_oe | output | 8 | Per-pin output enable |
| pull_up | output | 8 | Per-pin pull-up enable |
| irq_en | output | 8 | Per-pin interrupt source enable |
| pin_sync | output | 8 | Synchronized pin levels |

## Verification
The bench writes the data latch while pins are inputs and then switches them to outputs. A design that let the written value reach the pad early, or that lost it, shows up on pad_oe, pad_out and the data readback. Pad levels that conflict with the latch are applied to output pins, so a read mux that picks the wrong source returns the pad value instead of the latch. Pad levels also change one cycle at a time to test the two-edge input latency, which a synchronizer with one or three stages gets wrong. Option bits are set across both capable and non-capable pins and with both directions, to catch a pull-up or interrupt enable that ignores direction or the capability mask. The bench also issues reserved-address and deselected writes, which must leave every register unchanged.

// File: rtl/gpio_port_pkg.sv
// Package gpio_port_pkg: shared register address encoding for the GPIO port.
// Assumes a 2-bit register address space with one reserved slot.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_OPT  = 2'd2,
        REG_RSVD = 2'd3
    } gpio_reg_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Module gpio_in_sync: per-pin multi-flop synchronizer for raw pad levels.
// Assumes pad_in is asynchronous to clk. Output is reset to zero.
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] lvl_out
);
    localparam int CW = $clog2(STAGES + 1);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one synchronizer stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= pad_in;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign lvl_out = stage_q[STAGES-1];

    // Count cycles since reset so the latency check ignores reset-flushed stages.
    logic [CW-1:0] fill_q;
    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else if (fill_q != CW'(STAGES)) fill_q <= fill_q + 1'b1;
    end

    // R11: with two stages, output equals input two edges back once filled.
    a_r11_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (STAGES == 2 && fill_q == CW'(STAGES) && $past(rst_n) && $past(rst_n, 2))
            |-> lvl_out == $past(pad_in, 2));
endmodule

// File: rtl/gpio_regs.sv
// Module gpio_regs: data latch, direction and option registers plus read mux.
// Assumes single-cycle writes qualified by sel and wr; read is combinational.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic [WIDTH-1:0] pin_lvl,
    output logic [WIDTH-1:0] bus_rdata,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] opt_q
);
    logic wr_en;
    assign wr_en = bus_sel && bus_wr;

    // Update the register selected by a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            opt_q  <= '0;
        end else if (wr_en) begin
            case (gpio_reg_e'(bus_addr))
                REG_DATA: data_q <= bus_wdata;
                REG_DIR:  dir_q  <= bus_wdata;
                REG_OPT:  opt_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Select read data; the data slot returns latch for outputs, pin for inputs.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (gpio_reg_e'(bus_addr))
                REG_DATA: bus_rdata = (dir_q & data_q) | (~dir_q & pin_lvl);
                REG_DIR:  bus_rdata = dir_q;
                REG_OPT:  bus_rdata = opt_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R1: registers are clear on the edge after reset is sampled.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (data_q == '0 && dir_q == '0 && opt_q == '0));

    // R9: a direction write is held.
    a_r9_dir_written: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == REG_DIR) |=> dir_q == $past(bus_wdata));

    // R9: a reserved-slot write changes nothing.
    a_r9_rsvd_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == REG_RSVD) |=> ($stable(data_q) && $stable(dir_q) && $stable(opt_q)));

    // R10: deselected strobes change nothing.
    a_r10_desel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> ($stable(data_q) && $stable(dir_q) && $stable(opt_q)));
endmodule

// File: rtl/gpio_pin_ctrl.sv
// Module gpio_pin_ctrl: per-pin pad control decode from direction and option.
// Assumes IRQ_CAP is a build-time choice of interrupt-capable pins.
module gpio_pin_ctrl #(
    parameter int              WIDTH   = 8,
    parameter logic [WIDTH-1:0] IRQ_CAP = '0
) (
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] opt_q,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pull_up,
    output logic [WIDTH-1:0] irq_en
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            if (IRQ_CAP[i]) begin : g_irq
                // Interrupt-capable pin: option enables the interrupt when input.
                always_comb begin
                    pad_out[i] = data_q[i];
                    pad_oe[i]  = dir_q[i];
                    pull_up[i] = 1'b0;
                    irq_en[i]  = !dir_q[i] && opt_q[i];
                end
            end else begin : g_pu
                // Plain pin: option enables the pull-up when input.
                always_comb begin
                    pad_out[i] = data_q[i];
                    pad_oe[i]  = dir_q[i];
                    pull_up[i] = !dir_q[i] && opt_q[i];
                    irq_en[i]  = 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port.sv
// Module gpio_port: eight-pin bidirectional GPIO port, top level.
// Assumes pad_in is asynchronous; all outputs except bus_rdata come from registers
// through fixed decode.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter int               STAGES   = 2,
    parameter logic [WIDTH-1:0] IRQ_MASK = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pull_up,
    output logic [WIDTH-1:0] irq_en,
    output logic [WIDTH-1:0] pin_sync
);
    logic [WIDTH-1:0] data_q, dir_q, opt_q;

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .lvl_out(pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_lvl(pin_sync),
        .bus_rdata(bus_rdata), .data_q(data_q), .dir_q(dir_q), .opt_q(opt_q)
    );

    gpio_pin_ctrl #(.WIDTH(WIDTH), .IRQ_CAP(IRQ_MASK)) u_ctrl (
        .data_q(data_q), .dir_q(dir_q), .opt_q(opt_q),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up), .irq_en(irq_en)
    );

    // R7 and R8: a pin never has both pull-up and interrupt enable.
    a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up & irq_en) == '0);

    // R6: with all pins driven, a data read equals the driven value.
    a_r6_output_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == REG_DATA && pad_oe == '1) |-> bus_rdata == pad_out);

    // R7 and R8: output pins never have a pull-up or interrupt enable.
    a_r3_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & (pull_up | irq_en)) == '0));
endmodule

// File: tb/tb_gpio_port.sv
// Bench tb_gpio_port: behavioural reference model compared on every clock.
module tb_gpio_port;
    localparam logic [7:0] CAP = 8'h0F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00, pad_in = 8'h00;
    logic [7:0] bus_rdata, pad_out, pad_oe, pull_up, irq_en, pin_sync;

    always #4 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pull_up(pull_up), .irq_en(irq_en), .pin_sync(pin_sync)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Reference state.
    logic [7:0] m_lat = 0, m_dir = 0, m_opt = 0;
    logic [7:0] hist[$] = '{8'h00, 8'h00};

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_sync();
        return hist[1];
    endfunction

    // Compare all outputs against the model for current inputs.
    task automatic compare();
        logic [7:0] er;
        er = 8'h00;
        if (bus_sel) begin
            case (bus_addr)
                2'd0: er = (m_dir & m_lat) | (~m_dir & m_sync());
                2'd1: er = m_dir;
                2'd2: er = m_opt;
                default: er = 8'h00;
            endcase
        end
        check("R4/R6/R9/R10 bus_rdata", bus_rdata, er);
        check("R3 pad_oe", pad_oe, m_dir);
        check("R5 pad_out", pad_out, m_lat);
        check("R7 pull_up", pull_up, ~m_dir & m_opt & ~CAP);
        check("R8 irq_en", irq_en, ~m_dir & m_opt & CAP);
        check("R11 pin_sync", pin_sync, m_sync());
    endtask

    // One cycle: drive, compare, then advance model across the edge.
    task automatic tick(bit rst, bit sel, bit wr, logic [1:0] a, logic [7:0] wd, logic [7:0] pad);
        @(negedge clk);
        rst_n = rst; bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd; pad_in = pad;
        #1 compare();
        @(posedge clk);
        #1;
        if (!rst) begin
            m_lat = 0; m_dir = 0; m_opt = 0;
            hist = '{8'h00, 8'h00};
        end else begin
            hist.push_front(pad);
            void'(hist.pop_back());
            if (sel && wr) begin
                case (a)
                    2'd0: m_lat = wd;
                    2'd1: m_dir = wd;
                    2'd2: m_opt = wd;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, logic [7:0] pad);
        tick(1, 1, 1, a, d, pad);
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] pad);
        tick(1, 1, 0, a, 8'h00, pad);
    endtask

    initial begin
        // R1: reset state.
        for (int i = 0; i < 3; i++) tick(0, 0, 0, 2'd0, 8'h00, 8'hFF);
        rd(2'd0, 8'h00);
        check("R1 reset dir", pad_oe, 8'h00);
        check("R1 reset irq", irq_en | pull_up, 8'h00);
        // R4: input pins follow pad with two-edge latency, distinct patterns.
        for (int i = 0; i < 8; i++) rd(2'd0, 8'h01 << i);
        rd(2'd0, 8'hA5); rd(2'd0, 8'h5A); rd(2'd0, 8'h5A); rd(2'd0, 8'hFF); rd(2'd0, 8'h00);
        // R5: write latch while inputs; pad_oe stays low.
        wr(2'd0, 8'hC3, 8'h3C);
        rd(2'd0, 8'h3C); rd(2'd0, 8'h3C);
        check("R5 latch hidden while input", bus_rdata, 8'h3C);
        // R3/R6: switch to outputs; readback is latch despite conflicting pad.
        wr(2'd1, 8'hFF, 8'h3C);
        rd(2'd0, 8'h3C);
        check("R6 output readback", bus_rdata, 8'hC3);
        // R2: mixed direction, per-bit independence.
        wr(2'd1, 8'hF0, 8'h0F);
        rd(2'd0, 8'h0F); rd(2'd0, 8'h06); rd(2'd0, 8'h06);
        // R7/R8: option across capable and plain pins, both directions.
        wr(2'd2, 8'hFF, 8'h06);
        rd(2'd2, 8'h06);
        wr(2'd1, 8'h00, 8'h06); rd(2'd2, 8'h06);
        wr(2'd1, 8'h3C, 8'h06); rd(2'd1, 8'h06);
        wr(2'd2, 8'h81, 8'h06); rd(2'd2, 8'h06);
        // R9: reserved slot reads zero, write ignored.
        wr(2'd3, 8'hFF, 8'h06); rd(2'd3, 8'h06); rd(2'd1, 8'h06); rd(2'd2, 8'h06); rd(2'd0, 8'h06);
        // R10: deselected write ignored and read zero.
        tick(1, 0, 1, 2'd1, 8'h55, 8'h06);
        tick(1, 0, 1, 2'd0, 8'h55, 8'h06);
        rd(2'd1, 8'h06); rd(2'd0, 8'h06);
        // Sweep: data and direction patterns with moving pads.
        for (int k = 0; k < 16; k++) begin
            wr(2'(k % 3), 8'(k * 37 + 11), 8'(k * 53));
            rd(2'd0, 8'(k * 29));
            rd(2'd0, 8'(k * 29));
        end
        // R1: reset mid-run clears everything again.
        tick(0, 0, 0, 2'd0, 8'hFF, 8'hFF);
        rd(2'd0, 8'hFF); rd(2'd1, 8'hFF); rd(2'd2, 8'hFF);
        tick(1, 0, 0, 2'd0, 8'h00, 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule